// File: doc/BRIEF.md
# Dual-Channel Multiplexed Converter Receiver

This block sits behind a two-channel data converter that samples both of its channels at the same instant but returns the results over one shared 8-bit data bus. The converter places the channel A word on the bus after each rising edge of its clock and the channel B word after each falling edge. It also drives a channel-indicator line that is high during the A phase and low during the B phase. The receiver runs on the converter clock. It captures the bus on both clock edges and rebuilds the interleaved stream into pairs of samples that were taken at the same moment.

Each pair is converted from offset binary to two's complement and delivered with a single-cycle valid strobe. A sticky flag records any capture at which the indicator disagrees with the phase the receiver expects. A constant latency output gives the converter's pipeline depth in clock cycles. Downstream logic can use it to tag each pair with the cycle in which it was sampled. After reset the receiver emits nothing until it has seen an A capture, so the first pair delivered is always complete.

Top module: `dcmx_rx`

## Requirements
- R1: The channel A word, which is placed on the bus after a rising edge, is captured on the following falling edge.
- R2: The channel B word is captured on the rising edge. It is paired with the A word captured on the falling edge just before it. The pair appears on the outputs registered by that same rising edge.
- R3: With signed output selected, each code is mapped as (code − 128) in two's complement. 0x00 becomes −128 (0x80), 0x80 becomes 0, and 0xFF becomes +127 (0x7F).
- R4: `pair_vld` is registered on each rising edge that completes a pair. It is high for exactly that one cycle per pair, and data outputs change only when it is high.
- R5: `align_err` becomes 1 and stays 1 until reset in two cases: a falling-edge capture sees the indicator low, or a rising-edge capture sees it high.
- R6: After reset is released, `pair_vld` stays low at every rising edge that has not been preceded by a falling-edge capture made out of reset.
- R7: `lat_cyc` always equals the converter latency parameter, which is 5 by default.
- R8: An active-low reset clears `pair_vld`, `pair_a`, `pair_b` and `align_err` at once, without waiting for a clock edge.
- R9: Correct pairing does not depend on equal clock half-periods. It holds with a 40% high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_d | input | 8 | Shared converter data bus |
| adc_ind | input | 1 | Channel indicator, high in the A phase |
| pair_vld | output | 1 | One-cycle strobe for a new A/B pair |
| pair_a | output | 8 | Converted channel A sample |
| pair_b | output | 8 | Converted channel B sample |
| align_err | output | 1 | Sticky indicator/phase mismatch flag |
| lat_cyc | output | 3 | Converter latency in clock cycles |

## Verification
The bench builds the block with its defaults: 8-bit data, signed output, and a latency of 5. With an 8-bit width the directed codes 0x00, 0x80, 0xFF, 0x7F, 0x01 and 0xFE cover both full-scale ends and the mid-scale point of the conversion. Random words cover the rest of the code space. Signed output selects the conversion branch, which is the one that changes values. The bench uses an asymmetric 40/60 clock and injects indicator faults in each phase separately. This reaches both halves of the alignment check. Resets released just after a falling edge reach the warm-up guard.

// File: rtl/dcmx_pkg.sv
package dcmx_pkg;
   localparam int unsigned CHAN_N = 2;
   localparam int unsigned CH_IDX_A = 0;
   localparam int unsigned CH_IDX_B = 1;

   typedef enum logic {
      PH_B = 1'b0,
      PH_A = 1'b1
   } phase_e;

   function automatic logic ind_matches(input logic ind, input phase_e ph);
      return ind == logic'(ph);
   endfunction
endpackage

// File: rtl/dcmx_fall_cap.sv
module dcmx_fall_cap
   import dcmx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_i,
   input  logic              ind_i,
   output logic [DATA_W-1:0] a_word_o,
   output logic              a_seen_o,
   output logic              fall_err_o
);
   // A phase word is stable around the falling edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_word_o   <= '0;
         a_seen_o   <= 1'b0;
         fall_err_o <= 1'b0;
      end else begin
         a_word_o <= bus_i;
         a_seen_o <= 1'b1;
         if (!ind_matches(ind_i, PH_A)) begin
            fall_err_o <= 1'b1;
         end
      end
   end

   // R5: indicator low at a falling capture must raise the flag
   p_fall_ind_r5: assert property (@(negedge clk) disable iff (!rst_n)
      !ind_i |=> fall_err_o);

   // R5: flag never drops while out of reset
   p_fall_sticky_r5: assert property (@(negedge clk) disable iff (!rst_n)
      fall_err_o |=> fall_err_o);
endmodule

// File: rtl/dcmx_code_cvt.sv
module dcmx_code_cvt #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          SIGNED_OUT = 1'b1
) (
   input  logic [DATA_W-1:0] raw_i,
   output logic [DATA_W-1:0] cooked_o
);
   localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

   if (SIGNED_OUT) begin : g_twos
      logic signed [DATA_W:0] ref_v;

      assign cooked_o = {~raw_i[DATA_W-1], raw_i[DATA_W-2:0]};

      // R3: result equals code minus mid-scale
      always_comb begin
         ref_v = $signed({1'b0, raw_i}) - $signed({1'b0, MID});
         p_offset_map_r3: assert (ref_v == $signed({cooked_o[DATA_W-1], cooked_o}))
            else $error("offset map mismatch");
      end
   end else begin : g_raw
      assign cooked_o = raw_i;
   end
endmodule

// File: rtl/dcmx_pair.sv
module dcmx_pair
   import dcmx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ind_i,
   input  logic [DATA_W-1:0] cook_a_i,
   input  logic [DATA_W-1:0] cook_b_i,
   input  logic              a_seen_i,
   input  logic              fall_err_i,
   output logic              vld_o,
   output logic [DATA_W-1:0] pa_o,
   output logic [DATA_W-1:0] pb_o,
   output logic              err_o
);
   logic rise_err;

   // B phase word is stable around the rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o    <= 1'b0;
         pa_o     <= '0;
         pb_o     <= '0;
         rise_err <= 1'b0;
      end else begin
         vld_o <= a_seen_i;
         if (a_seen_i) begin
            pa_o <= cook_a_i;
            pb_o <= cook_b_i;
         end
         if (!ind_matches(ind_i, PH_B)) begin
            rise_err <= 1'b1;
         end
      end
   end

   assign err_o = rise_err | fall_err_i;

   // R5: indicator high at a rising capture must raise the flag
   p_rise_ind_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ind_i |=> err_o);

   // R5: combined flag is sticky
   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R6: no pair without a prior A capture
   p_vld_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> a_seen_i);

   // R4: data outputs hold while no pair is delivered
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |=> (vld_o || ($stable(pa_o) && $stable(pb_o))));
endmodule

// File: rtl/dcmx_rx.sv
module dcmx_rx
   import dcmx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter bit          SIGNED_OUT = 1'b1,
   parameter int unsigned CONV_LAT   = 5,
   parameter int unsigned LAT_W      = $clog2(CONV_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] adc_d,
   input  logic              adc_ind,
   output logic              pair_vld,
   output logic [DATA_W-1:0] pair_a,
   output logic [DATA_W-1:0] pair_b,
   output logic              align_err,
   output logic [LAT_W-1:0]  lat_cyc
);
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (LAT_W < $clog2(CONV_LAT + 1)) begin : g_bad_lat
      $error("LAT_W too narrow for CONV_LAT");
   end

   logic [DATA_W-1:0] raw_w  [CHAN_N];
   logic [DATA_W-1:0] cook_w [CHAN_N];
   logic              a_seen;
   logic              fall_err;
   logic [DATA_W-1:0] a_word;

   dcmx_fall_cap #(.DATA_W(DATA_W)) u_fall (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_i      (adc_d),
      .ind_i      (adc_ind),
      .a_word_o   (a_word),
      .a_seen_o   (a_seen),
      .fall_err_o (fall_err)
   );

   assign raw_w[CH_IDX_A] = a_word;
   assign raw_w[CH_IDX_B] = adc_d;

   for (genvar c = 0; c < CHAN_N; c++) begin : g_cvt
      dcmx_code_cvt #(.DATA_W(DATA_W), .SIGNED_OUT(SIGNED_OUT)) u_cvt (
         .raw_i    (raw_w[c]),
         .cooked_o (cook_w[c])
      );
   end

   dcmx_pair #(.DATA_W(DATA_W)) u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .ind_i      (adc_ind),
      .cook_a_i   (cook_w[CH_IDX_A]),
      .cook_b_i   (cook_w[CH_IDX_B]),
      .a_seen_i   (a_seen),
      .fall_err_i (fall_err),
      .vld_o      (pair_vld),
      .pa_o       (pair_a),
      .pb_o       (pair_b),
      .err_o      (align_err)
   );

   assign lat_cyc = LAT_W'(CONV_LAT);

   // R8: reset leaves no strobe or flag behind
   p_reset_clear_r8: assert property (@(posedge clk)
      !rst_n |-> (!pair_vld && !align_err));
endmodule

// File: tb/dcmx_rx_tb.sv
`timescale 1ns/10ps
module dcmx_rx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] adc_d = 8'h00;
   logic       adc_ind = 1'b0;
   logic       pair_vld;
   logic [7:0] pair_a, pair_b;
   logic       align_err;
   logic [2:0] lat_cyc;

   int total = 0;
   int bad = 0;
   int vld_seen = 0;
   int vld_exp = 0;

   logic       seen = 1'b0;
   logic       exp_vld = 1'b0;
   logic       exp_err = 1'b0;
   logic [7:0] exp_pa = 8'h00, exp_pb = 8'h00;
   logic [7:0] cur_a = 8'h00, cur_b = 8'h00;
   logic       pend_release = 1'b0;
   logic       bad_fall = 1'b0, bad_rise = 1'b0;
   bit         directed = 1'b0;
   int         dir_idx = 0;
   logic [7:0] dir_codes [6] = '{8'h00, 8'h80, 8'hFF, 8'h7F, 8'h01, 8'hFE};
   bit         done = 1'b0;

   dcmx_rx u_dut (
      .clk(clk), .rst_n(rst_n), .adc_d(adc_d), .adc_ind(adc_ind),
      .pair_vld(pair_vld), .pair_a(pair_a), .pair_b(pair_b),
      .align_err(align_err), .lat_cyc(lat_cyc)
   );

   // 250 MHz, 40% high phase (R9)
   initial forever begin
      #2.4 clk = 1'b1;
      #1.6 clk = 1'b0;
   end

   function automatic logic [7:0] exp_cvt(input logic [7:0] code);
      int s;
      s = int'(code) - 128;
      return s[7:0];
   endfunction

   function automatic logic [7:0] next_code();
      logic [7:0] v;
      if (directed) begin
         v = dir_codes[dir_idx % 6];
         dir_idx++;
      end else begin
         v = 8'($urandom);
      end
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_cycles(input int n, input string vreq);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         exp_vld = seen && rst_n;
         if (rst_n && adc_ind) exp_err = 1'b1;
         if (exp_vld) begin
            exp_pa = exp_cvt(cur_a);
            exp_pb = exp_cvt(cur_b);
         end
         #0.5;
         cur_a   = next_code();
         adc_d   = cur_a;
         adc_ind = !bad_fall;
         bad_fall = 1'b0;
         #0.5;
         chk(vreq, pair_vld, exp_vld);
         chk(directed ? "R3" : "R1", pair_a, exp_pa);
         chk(directed ? "R3" : "R2", pair_b, exp_pb);
         chk("R5", align_err, exp_err);
         if (pair_vld) vld_seen++;
         if (exp_vld) vld_exp++;
         @(negedge clk);
         if (rst_n) begin
            seen = 1'b1;
            if (!adc_ind) exp_err = 1'b1;
         end
         #0.5;
         cur_b   = next_code();
         adc_d   = cur_b;
         adc_ind = bad_rise;
         bad_rise = 1'b0;
         if (pend_release) begin
            #0.3;
            rst_n = 1'b1;
            pend_release = 1'b0;
         end
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      #0.2;
      chk("R8", pair_vld, 1'b0);
      chk("R8", align_err, 1'b0);
      chk("R8", pair_a, 8'h00);
      chk("R8", pair_b, 8'h00);
      seen = 1'b0;
      exp_err = 1'b0;
      exp_pa = 8'h00;
      exp_pb = 8'h00;
      pend_release = 1'b1;
      // released after the first falling-edge drive; next rising edge must not strobe
      run_cycles(1, "R8");
      run_cycles(1, "R6");
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      #1.0;
      chk("R8", pair_vld, 1'b0);
      chk("R8", align_err, 1'b0);
      chk("R7", lat_cyc, 3'd5);
      pend_release = 1'b1;
      run_cycles(1, "R8");
      run_cycles(1, "R6");
      directed = 1'b1;
      run_cycles(6, "R4");
      directed = 1'b0;
      vld_seen = 0;
      vld_exp = 0;
      run_cycles(40, "R4");
      chk("R9", vld_seen, vld_exp);
      chk("R7", lat_cyc, 3'd5);
      bad_rise = 1'b1;
      run_cycles(6, "R4");
      do_reset();
      run_cycles(4, "R4");
      bad_fall = 1'b1;
      run_cycles(6, "R4");
      do_reset();
      directed = 1'b1;
      run_cycles(6, "R4");
      directed = 1'b0;
      run_cycles(30, "R2");
      chk("R5", align_err, 1'b0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R4 watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule